// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block sits on the bus side of an external memory controller. It decodes a transfer address into one of several active-low chip-select strobes. Each channel holds a base value, a per-bit ignore mask over the upper sixteen address bits, a write-protect flag, a valid flag, and a control word. The control word sets the wait-state count, the automatic acknowledge, the port width, the byte-enable mode and the burst permissions. Software programs the channels through a small write-only register port.

A transfer begins with a one-clock start strobe. At that edge the block picks the lowest-numbered matching channel and latches its settings. It then holds that channel's strobe low until the cycle is acknowledged. The acknowledge comes either from an internal counter or from an external acknowledge input. While the strobe is low, the block reports the latched port width and permissions.

After reset, channel 0 acts as a global select that answers every address. It leaves that mode only when software sets its valid flag, so the other channels can be set up before then.

Top module: `csdec_top`

## Requirements
- R1: After reset no strobe is asserted and neither acknowledge nor error is raised. Channel 0 then answers any address, with 15 wait states, automatic acknowledge on, and a 16-bit port.
- R2: Channel n's registers sit at byte offsets 0x080 + 12·n. The base is at +0 and holds bits 31:16. The mask is at +4: bits 31:16 are the ignore flags, bit 8 is write-protect and bit 0 is valid. Control is at +8. Writes to any other offset change no channel.
- R3: A valid channel matches when every address bit 31:16 not flagged in its mask equals the base, so flagged bits create aliased regions.
- R4: Channel 0 answers all addresses only while its valid flag is clear. Once the flag is set, it answers only its own matching range.
- R5: When several channels match, the lowest-numbered one is selected, and at most one strobe is low at any time.
- R6: With control bit 8 set, the selected strobe goes low in the cycle after the start strobe. It stays low for (bits 13:10) + 1 cycles, `int_ack` is high in the last of these cycles only, and all strobes are high on the following cycle.
- R7: With control bit 8 clear, `int_ack` never rises. The strobe stays low until the clock at which `ext_ack` is sampled high, and is released on the next cycle.
- R8: While a strobe is low, `port_sz` reports control bits 7:6 as 00→00, 01→01 (8-bit), and 10 or 11→10 (16-bit). `bem_out`, `burst_rd_ok` and `burst_wr_ok` report control bits 5, 4 and 3. All four read zero when no strobe is low.
- R9: A write transfer whose selected channel is write-protected asserts no strobe. Instead it raises `xfer_err` for the single cycle after the start strobe. Read transfers to that channel run normally.
- R10: A start strobe whose address matches no channel asserts no strobe, no acknowledge and no error.
- R11: A start strobe that arrives while a cycle is in progress is ignored, and the running cycle keeps its channel and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | RAW (12) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| xfer_start | input | 1 | One-clock transfer start strobe |
| xfer_addr | input | AW (32) | Transfer address |
| xfer_write | input | 1 | Transfer is a write |
| ext_ack | input | 1 | External transfer acknowledge |
| cs_n | output | NCH (2) | Active-low chip-select strobes |
| int_ack | output | 1 | Internal transfer acknowledge |
| xfer_err | output | 1 | Write-protect violation pulse |
| port_sz | output | 2 | Normalised port width of the active channel |
| bem_out | output | 1 | Byte-enable mode of the active channel |
| burst_rd_ok | output | 1 | Burst reads permitted on the active channel |
| burst_wr_ok | output | 1 | Burst writes permitted on the active channel |

## Verification
The bench builds the decoder with its default parameters: two channels, a 32-bit address, a 12-bit register offset, base offset 0x080 and a 12-byte stride. Two channels are enough to reach the priority case where both match, and to check that global channel 0 overrides a channel that is already valid. The 4-bit wait field reaches both its extremes: 0 wait states, where the acknowledge comes in the first strobe cycle, and the reset value of 15 wait states. A 12-bit offset also lets the bench write to addresses just outside the register block.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int HI_W = 16;
  localparam int WS_W = 4;

  typedef struct packed {
    logic [HI_W-1:0] base;
    logic [HI_W-1:0] ign;
    logic            wp;
    logic            valid;
    logic [WS_W-1:0] ws;
    logic            aa;
    logic [1:0]      ps;
    logic            bem;
    logic            brd;
    logic            bwr;
  } chan_cfg_t;

  // reset contents: channel 0 is the global select, others are empty
  function automatic chan_cfg_t cfg_reset(input int ch);
    chan_cfg_t c;
    c = '0;
    if (ch == 0) begin
      c.ws = '1;
      c.aa = 1'b1;
      c.ps = 2'b10;
    end
    return c;
  endfunction

  // unflagged upper bits must equal the base
  function automatic logic addr_hit(input logic [HI_W-1:0] a,
                                    input logic [HI_W-1:0] b,
                                    input logic [HI_W-1:0] ign);
    return ((a ^ b) & ~ign) == '0;
  endfunction

  // both 16-bit encodings collapse onto 2'b10
  function automatic logic [1:0] norm_ps(input logic [1:0] ps);
    return ps[1] ? 2'b10 : ps;
  endfunction
endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
  import csdec_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int RAW      = 12,
  parameter int REG_BASE = 'h080,
  parameter int STRIDE   = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RAW-1:0] addr,
  input  logic [31:0]    wdata,
  output chan_cfg_t      cfg [NCH]
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[15:14], wdata[9], wdata[2:1]};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [RAW-1:0] OFS_B = RAW'(REG_BASE + STRIDE * g);
    localparam logic [RAW-1:0] OFS_M = RAW'(REG_BASE + STRIDE * g + 4);
    localparam logic [RAW-1:0] OFS_C = RAW'(REG_BASE + STRIDE * g + 8);
    chan_cfg_t r_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_q <= cfg_reset(g);
      end else if (we) begin
        if (addr == OFS_B) begin
          r_q.base <= wdata[31:16];
        end
        if (addr == OFS_M) begin
          r_q.ign   <= wdata[31:16];
          r_q.wp    <= wdata[8];
          r_q.valid <= wdata[0];
        end
        if (addr == OFS_C) begin
          r_q.ws  <= wdata[13:10];
          r_q.aa  <= wdata[8];
          r_q.ps  <= wdata[7:6];
          r_q.bem <= wdata[5];
          r_q.brd <= wdata[4];
          r_q.bwr <= wdata[3];
        end
      end
    end

    assign cfg[g] = r_q;
  end
endmodule

// File: rtl/csdec_match.sv
module csdec_match
  import csdec_pkg::*;
#(
  parameter int NCH = 2,
  parameter int IW  = 1
) (
  input  logic [HI_W-1:0] addr_hi,
  input  chan_cfg_t       cfg [NCH],
  output logic [NCH-1:0]  hit_vec,
  output logic            any_hit,
  output logic [IW-1:0]   sel
);
  for (genvar g = 0; g < NCH; g++) begin : g_hit
    if (g == 0) begin : g_global
      assign hit_vec[g] = !cfg[g].valid ||
                          addr_hit(addr_hi, cfg[g].base, cfg[g].ign);
    end else begin : g_plain
      assign hit_vec[g] = cfg[g].valid &&
                          addr_hit(addr_hi, cfg[g].base, cfg[g].ign);
    end
  end

  assign any_hit = |hit_vec;

  // scan downward so the lowest index is written last and wins
  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel = IW'(i);
    end
  end
endmodule

// File: rtl/csdec_seq.sv
module csdec_seq
  import csdec_pkg::*;
#(
  parameter int NCH = 2,
  parameter int IW  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            write,
  input  logic            any_hit,
  input  logic [IW-1:0]   sel,
  input  chan_cfg_t       sel_cfg,
  input  logic            ext_ack,
  output logic [NCH-1:0]  cs_n,
  output logic            int_ack,
  output logic            xfer_err,
  output logic [1:0]      port_sz,
  output logic            bem_out,
  output logic            burst_rd_ok,
  output logic            burst_wr_ok,
  output logic            busy,
  output logic            cyc_done,
  output logic            act_aa,
  output logic [WS_W-1:0] act_ws
);
  logic            busy_q, err_q;
  logic [IW-1:0]   cur_q;
  logic [WS_W-1:0] cnt_q;
  chan_cfg_t       lat_q;
  logic            launch, blocked;

  assign blocked = write && sel_cfg.wp;
  assign launch  = !busy_q && start && any_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cur_q  <= '0;
      cnt_q  <= '0;
      lat_q  <= '0;
    end else begin
      err_q <= launch && blocked;
      if (launch && !blocked) begin
        busy_q <= 1'b1;
        cur_q  <= sel;
        cnt_q  <= sel_cfg.ws;
        lat_q  <= sel_cfg;
      end else if (busy_q) begin
        if (cyc_done) busy_q <= 1'b0;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign int_ack  = busy_q && lat_q.aa && (cnt_q == '0);
  assign cyc_done = busy_q && (lat_q.aa ? (cnt_q == '0) : ext_ack);

  for (genvar g = 0; g < NCH; g++) begin : g_cs
    assign cs_n[g] = !(busy_q && (cur_q == IW'(g)));
  end

  assign xfer_err    = err_q;
  assign port_sz     = busy_q ? norm_ps(lat_q.ps) : 2'b00;
  assign bem_out     = busy_q && lat_q.bem;
  assign burst_rd_ok = busy_q && lat_q.brd;
  assign burst_wr_ok = busy_q && lat_q.bwr;
  assign busy        = busy_q;
  assign act_aa      = lat_q.aa;
  assign act_ws      = lat_q.ws;

  logic unused_lat;
  assign unused_lat = ^{lat_q.base, lat_q.ign, lat_q.wp, lat_q.valid};
endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int AW       = 32,
  parameter int RAW      = 12,
  parameter int REG_BASE = 'h080,
  parameter int STRIDE   = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  input  logic           xfer_start,
  input  logic [AW-1:0]  xfer_addr,
  input  logic           xfer_write,
  input  logic           ext_ack,
  output logic [NCH-1:0] cs_n,
  output logic           int_ack,
  output logic           xfer_err,
  output logic [1:0]     port_sz,
  output logic           bem_out,
  output logic           burst_rd_ok,
  output logic           burst_wr_ok
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  chan_cfg_t       cfg [NCH];
  logic [NCH-1:0]  hit_vec;
  logic            any_hit;
  logic [IW-1:0]   sel;
  logic [HI_W-1:0] addr_hi;
  // events brought out for the checker
  logic            busy_w, cyc_done_w, act_aa_w;
  logic [WS_W-1:0] act_ws_w;

  assign addr_hi = xfer_addr[AW-1 -: HI_W];
  logic unused_lo;
  assign unused_lo = ^{xfer_addr[AW-HI_W-1:0], hit_vec};

  csdec_regs #(.NCH(NCH), .RAW(RAW), .REG_BASE(REG_BASE), .STRIDE(STRIDE)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .cfg(cfg)
  );

  csdec_match #(.NCH(NCH), .IW(IW)) u_match (
    .addr_hi(addr_hi), .cfg(cfg), .hit_vec(hit_vec),
    .any_hit(any_hit), .sel(sel)
  );

  csdec_seq #(.NCH(NCH), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .write(xfer_write),
    .any_hit(any_hit), .sel(sel), .sel_cfg(cfg[sel]), .ext_ack(ext_ack),
    .cs_n(cs_n), .int_ack(int_ack), .xfer_err(xfer_err),
    .port_sz(port_sz), .bem_out(bem_out), .burst_rd_ok(burst_rd_ok),
    .burst_wr_ok(burst_wr_ok), .busy(busy_w), .cyc_done(cyc_done_w),
    .act_aa(act_aa_w), .act_ws(act_ws_w)
  );
endmodule

// File: rtl/csdec_chk.sv
module csdec_chk #(
  parameter int NCH  = 2,
  parameter int WS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  cs_n,
  input logic            int_ack,
  input logic            xfer_err,
  input logic            busy,
  input logic            cyc_done,
  input logic            act_aa,
  input logic [WS_W-1:0] act_ws
);
  logic [7:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (busy && !cyc_done) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  assert_onehot_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_err_no_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> (&cs_n));

  assert_no_int_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !act_aa) |-> !int_ack);

  assert_ack_with_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> !(&cs_n));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> (&cs_n));

  assert_hold_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_done) |=> $stable(cs_n));

  assert_wait_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> (run_q == 8'(act_ws)));
endmodule

bind csdec_top csdec_chk #(.NCH(NCH), .WS_W(csdec_pkg::WS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .int_ack(int_ack),
  .xfer_err(xfer_err), .busy(busy_w), .cyc_done(cyc_done_w),
  .act_aa(act_aa_w), .act_ws(act_ws_w)
);

// File: tb/csdec_top_test.sv
module csdec_top_test;
  localparam int NCH = 2;
  localparam int NV  = 8;
  localparam logic [31:0] V_ADDR [NV] = '{32'h0000_0000, 32'h001F_FFFC,
    32'h8010_0000, 32'h801F_FFFF, 32'h0080_0000, 32'h009F_FFF0,
    32'h00A0_0000, 32'h4000_0000};
  localparam int V_CH  [NV] = '{1, 1, 1, 1, 0, 0, -1, -1};
  localparam int V_LEN [NV] = '{3, 3, 3, 3, 4, 4, 0, 0};
  localparam int V_PS  [NV] = '{2, 2, 2, 2, 2, 2, 0, 0};
  localparam int V_BEM [NV] = '{1, 1, 1, 1, 0, 0, 0, 0};
  localparam int V_BRD [NV] = '{1, 1, 1, 1, 0, 0, 0, 0};

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, xfer_addr = '0;
  logic xfer_start = 1'b0, xfer_write = 1'b0, ext_ack = 1'b0;
  logic [NCH-1:0] cs_n;
  logic int_ack, xfer_err, bem_out, burst_rd_ok, burst_wr_ok;
  logic [1:0] port_sz;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  csdec_top uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .xfer_start(xfer_start), .xfer_addr(xfer_addr),
    .xfer_write(xfer_write), .ext_ack(ext_ack), .cs_n(cs_n),
    .int_ack(int_ack), .xfer_err(xfer_err), .port_sz(port_sz),
    .bem_out(bem_out), .burst_rd_ok(burst_rd_ok), .burst_wr_ok(burst_wr_ok)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  int r_ch, r_len, r_ack, r_err, r_ps, r_bem, r_brd, r_bwr;

  // start one transfer, then sample at each falling edge until release
  task automatic run_xfer(input logic [31:0] a, input logic wr);
    @(negedge clk);
    xfer_addr = a; xfer_write = wr; xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    r_ch = -1; r_len = 0; r_ack = 0;
    r_err = int'(xfer_err); r_ps = int'(port_sz); r_bem = int'(bem_out);
    r_brd = int'(burst_rd_ok); r_bwr = int'(burst_wr_ok);
    for (int k = 0; k < 40; k++) begin
      if (&cs_n) break;
      for (int c = 0; c < NCH; c++) if (!cs_n[c]) r_ch = c;
      r_len++;
      if (int_ack) r_ack = r_len;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cs_n reset", int'(cs_n), 3);
    check("R1 int_ack reset", int'(int_ack), 0);
    check("R1 xfer_err reset", int'(xfer_err), 0);
    rst_n = 1'b1;

    // R1 global select after reset
    run_xfer(32'h1234_5678, 1'b0);
    check("R1 global ch", r_ch, 0);
    check("R1 global len", r_len, 16);
    check("R1 global ack pos", r_ack, 16);
    check("R1 global ps", r_ps, 2);

    // R11 second start mid-cycle is ignored
    @(negedge clk);
    xfer_addr = 32'h0000_0000; xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    r_len = 0;
    for (int k = 0; k < 40; k++) begin
      if (&cs_n) break;
      r_len++;
      xfer_start = (k == 3);
      @(negedge clk);
    end
    xfer_start = 1'b0;
    check("R11 len with restart", r_len, 16);
    repeat (3) @(negedge clk);
    check("R11 no second cycle", int'(cs_n), 3);

    // program channel 1 first, global mode still on
    wr_reg(12'h08C, 32'h0000_0000);
    wr_reg(12'h094, 32'h0000_09B0);
    wr_reg(12'h090, 32'h801F_0001);
    run_xfer(32'h0000_0000, 1'b0);
    check("R4 global overrides valid ch1", r_ch, 0);
    check("R5 global priority len", r_len, 16);

    // channel 0, then leave global mode
    wr_reg(12'h080, 32'h0080_0000);
    wr_reg(12'h088, 32'h0000_0D80);
    wr_reg(12'h084, 32'h001F_0001);
    // R2 writes outside the register block change nothing
    wr_reg(12'h098, 32'hFFFF_0001);
    wr_reg(12'h07C, 32'hFFFF_0001);

    // R3 R6 R8 R10 vector table
    for (int v = 0; v < NV; v++) begin
      run_xfer(V_ADDR[v], 1'b0);
      check($sformatf("R3 vec%0d ch", v), r_ch, V_CH[v]);
      check($sformatf("R6 vec%0d len", v), r_len, V_LEN[v]);
      check($sformatf("R6 vec%0d ack", v), r_ack, V_LEN[v]);
      check($sformatf("R8 vec%0d ps", v), r_ps, V_PS[v]);
      check($sformatf("R8 vec%0d bem", v), r_bem, V_BEM[v]);
      check($sformatf("R8 vec%0d brd", v), r_brd, V_BRD[v]);
      check($sformatf("R8 vec%0d bwr", v), r_bwr, 0);
      check($sformatf("R10 vec%0d err", v), r_err, 0);
    end

    // R7 external acknowledge
    wr_reg(12'h094, 32'h0000_08B0);
    @(negedge clk);
    xfer_addr = 32'h0000_0000; xfer_write = 1'b0; xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    r_ack = 0; r_len = 0;
    for (int k = 0; k < 6; k++) begin
      if (!cs_n[1]) r_len++;
      if (int_ack) r_ack++;
      @(negedge clk);
    end
    check("R7 held without ext_ack", r_len, 6);
    check("R7 no int_ack", r_ack, 0);
    ext_ack = 1'b1;
    @(negedge clk);
    ext_ack = 1'b0;
    check("R7 release after ext_ack", int'(cs_n), 3);

    // R8 8-bit port with zero wait states, then the 11 encoding
    wr_reg(12'h094, 32'h0000_0140);
    run_xfer(32'h0000_0000, 1'b0);
    check("R8 8-bit ps", r_ps, 1);
    check("R6 zero-wait len", r_len, 1);
    check("R6 zero-wait ack", r_ack, 1);
    wr_reg(12'h094, 32'h0000_01C0);
    run_xfer(32'h0000_0000, 1'b0);
    check("R8 ps 11 gives 16-bit", r_ps, 2);

    // R9 write protect
    wr_reg(12'h094, 32'h0000_09B0);
    wr_reg(12'h090, 32'h801F_0101);
    run_xfer(32'h0000_0000, 1'b1);
    check("R9 protected write cs", r_ch, -1);
    check("R9 protected write err", r_err, 1);
    @(negedge clk);
    check("R9 err one cycle", int'(xfer_err), 0);
    run_xfer(32'h0000_0000, 1'b0);
    check("R9 protected read ch", r_ch, 1);
    check("R9 protected read err", r_err, 0);
    run_xfer(32'h0080_0000, 1'b1);
    check("R9 unprotected write ch", r_ch, 0);
    check("R9 unprotected write len", r_len, 4);

    // R5 overlapping channels
    wr_reg(12'h08C, 32'h0080_0000);
    wr_reg(12'h090, 32'h001F_0001);
    run_xfer(32'h0090_0000, 1'b0);
    check("R5 overlap lowest wins", r_ch, 0);
    check("R5 overlap len", r_len, 4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule